// File: doc/BRIEF.md
# CAN Test-Mode Pin Controller

This block holds the test-mode register of a CAN controller and the small amount of logic that this register steers. It sits between the protocol core and the physical transmit and receive pins. Software reaches the register through a simple register bus port. The register accepts writes only while a test-enable bit from a separate configuration register is set. When that bit drops, every field returns to its reset value.

The transmit field chooses what drives the transmit pin. It can pass the core's bit, updated only on bit boundaries. It can make sample-point strobes visible on the pin. It can also hold the pin dominant or hold it recessive. The loop-back field routes the core's own transmit bit back into the core's receive input, in place of the external pin. A read-only bit shows the synchronised level of the receive pin.

Top module: `can_testpin_ctrl`

## Requirements
- R1: A write to the register (offset 0x10) changes its fields only while `test_en` is 1. A write made while `test_en` is 0 leaves every field, `lpbk_en` and `tx_pin` unchanged.
- R2: In any cycle where `test_en` is 0 at a clock edge, the transmit field returns to 00 and the loop-back field returns to 0.
- R3: A read at offset 0x10 returns the register. Bits 31:8 and 3:0 read as 0 and ignore writes. A read at any other offset returns 0, and a write to any other offset changes nothing. After reset the fields are 0.
- R4: Bit 7 of the read value is the receive pin level after a two-flop synchroniser, which resets to 1 (recessive). A change on `rx_pin` shows up in bit 7 after the second clock edge, not the first.
- R5: With the transmit field (bits 6:5) at 00, `tx_pin` takes the value of `core_tx` one clock after a cycle in which `bit_end` is high. In every other cycle `tx_pin` holds its value.
- R6: With the transmit field at 01, `tx_pin` is 1 in the clock after each cycle in which `samp_pt` is high, and 0 otherwise.
- R7: With the transmit field at 10, `tx_pin` is 0 from the next clock. With the field at 11, `tx_pin` is 1 from the next clock.
- R8: Bit 4 is the loop-back field and is driven on `lpbk_en`. While it is 1, `rx_core` equals `core_tx`. While it is 0, `rx_core` equals the synchronised receive level.
- R9: After reset, `tx_pin` is 1 (recessive) and `lpbk_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, 0 when not selected) |
| test_en | input | 1 | Test-enable bit from the configuration register |
| rx_pin | input | 1 | Raw receive pin (0 dominant, 1 recessive) |
| core_tx | input | 1 | Transmit bit from the protocol core |
| bit_end | input | 1 | One-cycle strobe at the end of each bit time |
| samp_pt | input | 1 | One-cycle strobe at each sample point |
| tx_pin | output | 1 | Transmit pin (registered) |
| lpbk_en | output | 1 | Loop-back mode enable |
| rx_core | output | 1 | Receive bit handed to the core |

## Verification
The bench attacks the write gate in two ways. First it writes a dominant-forcing value while `test_en` is low; a design without the gate would pull `tx_pin` to 0 and set `lpbk_en`. Second it drops `test_en` for a single cycle; a design that missed the clear would keep reading 0xF0. In core mode it changes `core_tx` between boundary strobes, so a design that followed the core bit freely would move the pin early. It also checks that the pin stays put across a mode switch back to 00. It measures the receive synchroniser to the exact edge: one stage too few or too many would flip bit 7 a cycle early or late. Finally it sets the loop-back field with the external pin held recessive and the core bit dominant, so wrong routing shows up at once.

// File: rtl/can_tst_pkg.sv
package can_tst_pkg;

    typedef enum logic [1:0] {
        TXM_CORE   = 2'b00,
        TXM_SAMPLE = 2'b01,
        TXM_DOM    = 2'b10,
        TXM_REC    = 2'b11
    } txm_e;

    typedef struct packed {
        txm_e txm;
        logic lbk;
    } tst_fields_t;

    localparam int unsigned RX_BIT  = 7;
    localparam int unsigned TXM_LSB = 5;
    localparam int unsigned LBK_BIT = 4;

endpackage

// File: rtl/can_tst_rxsync.sv
module can_tst_rxsync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_raw,
    output logic rx_lvl
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (STAGES > 1) begin
            st_d.chain = {st_q.chain[STAGES-2:0], rx_raw};
        end else begin
            st_d.chain = rx_raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{chain: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_lvl = st_q.chain[STAGES-1];

endmodule

// File: rtl/can_tst_regs.sv
module can_tst_regs
    import can_tst_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              test_en,
    input  logic              rx_lvl,
    output tst_fields_t       fields
);
    typedef struct packed {
        tst_fields_t f;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    hit;
    logic    wr_hit;
    logic    unused_wdata;

    assign hit    = bus_sel && (bus_addr == REG_OFFSET);
    assign wr_hit = hit && bus_wr;
    assign unused_wdata = ^{bus_wdata[DATA_W-1:RX_BIT], bus_wdata[LBK_BIT-1:0]};

    always_comb begin
        st_d = st_q;
        if (!test_en) begin
            st_d.f = '0;
        end else if (wr_hit) begin
            st_d.f.txm = txm_e'(bus_wdata[TXM_LSB +: 2]);
            st_d.f.lbk = bus_wdata[LBK_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit && !bus_wr) begin
            bus_rdata[RX_BIT]         = rx_lvl;
            bus_rdata[TXM_LSB +: 2]   = st_q.f.txm;
            bus_rdata[LBK_BIT]        = st_q.f.lbk;
        end
    end

    assign fields = st_q.f;

    // R1: a gated write lands on the next edge
    assert_wr_takes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && test_en) |=> (fields.lbk == $past(bus_wdata[LBK_BIT])));

    // R1: without a write the fields hold while test mode stays on
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && test_en) |=> $stable(fields));

    // R2: leaving test mode clears every field
    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> (fields == '0));

endmodule

// File: rtl/can_tst_txmux.sv
module can_tst_txmux
    import can_tst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  txm_e txm,
    input  logic core_tx,
    input  logic bit_end,
    input  logic samp_pt,
    output logic tx_pin
);
    typedef struct packed {
        logic tx;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (txm)
            TXM_CORE:   if (bit_end) st_d.tx = core_tx;
            TXM_SAMPLE: st_d.tx = samp_pt;
            TXM_DOM:    st_d.tx = 1'b0;
            TXM_REC:    st_d.tx = 1'b1;
            default:    st_d.tx = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{tx: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_pin = st_q.tx;

    assert_core_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (txm == TXM_CORE && bit_end) |=> (tx_pin == $past(core_tx)));

    assert_core_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (txm == TXM_CORE && !bit_end) |=> $stable(tx_pin));

    assert_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (txm == TXM_SAMPLE) |=> (tx_pin == $past(samp_pt)));

    assert_dom_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (txm == TXM_DOM) |=> !tx_pin);

    assert_rec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (txm == TXM_REC) |=> tx_pin);

endmodule

// File: rtl/can_testpin_ctrl.sv
module can_testpin_ctrl
    import can_tst_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              test_en,
    input  logic              rx_pin,
    input  logic              core_tx,
    input  logic              bit_end,
    input  logic              samp_pt,
    output logic              tx_pin,
    output logic              lpbk_en,
    output logic              rx_core
);
    tst_fields_t fields;
    logic        rx_lvl;

    can_tst_rxsync #(.STAGES(SYNC_STAGES)) u_rxsync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_raw (rx_pin),
        .rx_lvl (rx_lvl)
    );

    can_tst_regs #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .test_en   (test_en),
        .rx_lvl    (rx_lvl),
        .fields    (fields)
    );

    can_tst_txmux u_txmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .txm     (fields.txm),
        .core_tx (core_tx),
        .bit_end (bit_end),
        .samp_pt (samp_pt),
        .tx_pin  (tx_pin)
    );

    assign lpbk_en = fields.lbk;
    assign rx_core = fields.lbk ? core_tx : rx_lvl;

endmodule

// File: tb/can_testpin_ctrl_bench.sv
module can_testpin_ctrl_bench;

    localparam logic [7:0] REG_ADDR = 8'h10;

    // {mode[1:0], core_tx, bit_end, samp_pt, expected tx_pin}
    localparam logic [5:0] VEC [16] = '{
        6'b00_0_0_0_1, 6'b00_0_1_0_0, 6'b00_1_0_0_0, 6'b00_1_1_0_1,
        6'b00_0_0_0_1, 6'b01_0_0_1_1, 6'b01_0_0_0_0, 6'b01_1_1_1_1,
        6'b01_1_0_0_0, 6'b10_1_1_1_0, 6'b10_1_0_0_0, 6'b11_0_1_0_1,
        6'b11_0_0_0_1, 6'b00_0_0_0_1, 6'b00_0_1_0_0, 6'b00_1_0_1_0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        test_en = 1'b0;
    logic        rx_pin = 1'b1;
    logic        core_tx = 1'b1;
    logic        bit_end = 1'b0;
    logic        samp_pt = 1'b0;
    logic        tx_pin;
    logic        lpbk_en;
    logic        rx_core;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    can_testpin_ctrl u_can_testpin_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .test_en   (test_en),
        .rx_pin    (rx_pin),
        .core_tx   (core_tx),
        .bit_end   (bit_end),
        .samp_pt   (samp_pt),
        .tx_pin    (tx_pin),
        .lpbk_en   (lpbk_en),
        .rx_core   (rx_core)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        bit_end = 1'b0; samp_pt = 1'b0;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        logic [1:0]  cur_mode;
        string       tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state: R3, R9
        bus_read(REG_ADDR, rd);
        chk("R3 reset read", rd, 32'h80);
        chk("R9 reset tx_pin", {31'b0, tx_pin}, 32'h1);
        chk("R9 reset lpbk_en", {31'b0, lpbk_en}, 32'h0);

        // R1: write with test mode off is ignored
        bus_write(REG_ADDR, 32'h50);
        @(negedge clk);
        bus_read(REG_ADDR, rd);
        chk("R1 gated write read", rd, 32'h80);
        chk("R1 gated write tx_pin", {31'b0, tx_pin}, 32'h1);
        chk("R1 gated write lpbk_en", {31'b0, lpbk_en}, 32'h0);

        // R3: reserved bits, R8: loop-back routing
        test_en = 1'b1;
        @(negedge clk);
        bus_write(REG_ADDR, 32'hFFFF_FFFF);
        bus_read(REG_ADDR, rd);
        chk("R3 reserved bits read zero", rd, 32'hF0);
        chk("R8 lpbk_en set", {31'b0, lpbk_en}, 32'h1);
        core_tx = 1'b0;
        #0.5;
        chk("R8 loopback core 0", {31'b0, rx_core}, 32'h0);
        core_tx = 1'b1;
        #0.5;
        chk("R8 loopback core 1", {31'b0, rx_core}, 32'h1);
        @(negedge clk);

        // R3: other offsets
        bus_write(8'h14, 32'h0);
        bus_read(REG_ADDR, rd);
        chk("R3 foreign write no effect", rd, 32'hF0);
        bus_read(8'h14, rd);
        chk("R3 foreign read zero", rd, 32'h0);

        // R2: one-cycle drop of test mode clears fields
        test_en = 1'b0;
        @(negedge clk);
        test_en = 1'b1;
        bus_read(REG_ADDR, rd);
        chk("R2 cleared on exit", rd, 32'h80);
        chk("R2 lpbk_en cleared", {31'b0, lpbk_en}, 32'h0);
        core_tx = 1'b0;
        #0.5;
        chk("R8 no loopback uses rx", {31'b0, rx_core}, 32'h1);

        // R4: two-stage synchroniser latency
        @(negedge clk);
        rx_pin = 1'b0;
        @(negedge clk);
        bus_read(REG_ADDR, rd);
        chk("R4 rx after one edge", rd, 32'h80);
        @(negedge clk);
        bus_read(REG_ADDR, rd);
        chk("R4 rx after two edges", rd, 32'h00);
        chk("R8 rx_core follows synced rx", {31'b0, rx_core}, 32'h0);
        rx_pin = 1'b1;
        repeat (2) @(negedge clk);

        // vector walk over transmit modes: R5, R6, R7
        cur_mode = 2'b00;
        for (int i = 0; i < 16; i++) begin
            if (VEC[i][5:4] != cur_mode) begin
                cur_mode = VEC[i][5:4];
                bus_write(REG_ADDR, {25'd0, cur_mode, 5'd0});
            end
            core_tx = VEC[i][3];
            bit_end = VEC[i][2];
            samp_pt = VEC[i][1];
            @(negedge clk);
            case (cur_mode)
                2'b00:   tag = $sformatf("R5 vec %0d", i);
                2'b01:   tag = $sformatf("R6 vec %0d", i);
                default: tag = $sformatf("R7 vec %0d", i);
            endcase
            chk(tag, {31'b0, tx_pin}, {31'b0, VEC[i][0]});
        end
        bit_end = 1'b0;
        samp_pt = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule